// File: doc/BRIEF.md
# Phase interval timer

This block times one attempt of a target system's startup phase. While idle it holds the target in reset through an open-drain style output, where a drive enable of 1 pulls the line low and 0 leaves it floating. A single start pulse releases the target and clears a free-running interval counter. Every rising edge of the target's asynchronous chip-enable strobe clears that counter again, so the count that is finally reported is measured from the last strobe edge.

The block watches the target's 8-bit status code. A code change only counts once the code has passed through a synchroniser and then held steady for a set number of cycles. The monitored phase begins when the filtered code becomes 0x21 and ends on the first filtered change away from it. At that moment the block captures the count, sorts the outcome by the code that follows, pulls the target back into reset and offers the result on a valid/ready interface.

If the end never arrives, a programmable number of counter wraps ends the attempt as a timeout. Attempts can be repeated without limit.

Top module: `phase_interval_timer`

## Requirements
- R1: `tgt_rst_low_o` is 1 after reset and while idle. It is 0 from the cycle after an accepted start until the result is captured. It is 1 again, together with `res_valid_o`, from then on.
- R2: Each synchronised rising edge of `strobe_i` clears the counter. Let D be the number of clock cycles between the sampling of the last strobe rise and the sampling of the code that ends the phase. A fail result then reports a count of D+1 with the default filter length of 2.
- R3: The measurement enters its phase only once the filtered code equals 0x21. It ends on the first filtered code that differs from 0x21.
- R4: An end code of 0xA4 gives kind 0 (fail), the captured count and `res_code_o` = 0xA4.
- R5: An end code of 0x22 or 0x2F gives kind 1 (pass) and a count of 0.
- R6: Any other end code gives kind 2 (error), with that code in `res_code_o` and a count of 0.
- R7: Suppose no end arrives and `ovf_limit_i` = L is nonzero. On the L-th counter wrap after the start, the result is kind 3 (timeout), with a count of 0 and the current filtered code. With L = 1 and no strobe edge, this happens 65536 cycles after the start is accepted.
- R8: A status code must hold for 2 consecutive synchronised samples before it is accepted. A value that is present for a single cycle has no effect on the outcome or the count.
- R9: A start pulse while `busy_o` is 1 is ignored. It does not restart the count, and after the result is consumed the block is idle.
- R10: `res_valid_o` and the result fields stay stable until `res_ready_i` is seen. The block then returns to idle with `busy_o` = 0, ready for another attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle measurement request |
| strobe_i | input | 1 | Asynchronous chip-enable strobe from the target |
| code_i | input | 8 | Asynchronous status code from the target |
| ovf_limit_i | input | 8 | Counter wraps allowed before timeout; 0 disables the timeout |
| tgt_rst_low_o | output | 1 | 1 drives the target reset low, 0 releases it to high impedance |
| busy_o | output | 1 | An attempt is running or its result is pending |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_kind_o | output | 2 | 0 fail, 1 pass, 2 error, 3 timeout |
| res_count_o | output | 16 | Captured count, valid for fail |
| res_code_o | output | 8 | Filtered code that ended the attempt |

## Verification
The assertions assume a single-cycle start pulse and a consumer that may hold ready low for any number of cycles. They also assume that the status code holds each meaningful value for at least a few cycles, so that only deliberate glitches are shorter than the filter length. The stimulus changes every input on the falling edge, keeps strobe edges several cycles apart, and holds each code long enough to be accepted. The one exception is a single-cycle glitch value that is injected on purpose. Random delays, strobe counts and end codes are drawn from a fixed seed, and each expected kind and count is computed from D.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [1:0] {
      KIND_FAIL    = 2'd0,
      KIND_PASS    = 2'd1,
      KIND_ERROR   = 2'd2,
      KIND_TIMEOUT = 2'd3
   } pit_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ENTER,
      ST_PHASE,
      ST_REPORT
   } pit_state_e;

endpackage

// File: rtl/pit_sync.sv
module pit_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= d_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[g] <= '0;
         else        stg_q[g] <= stg_q[g-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pit_code_filter.sv
module pit_code_filter #(
   parameter int CODE_W        = 8,
   parameter int STABLE_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] raw_i,
   output logic [CODE_W-1:0] code_o
);

   logic [CODE_W-1:0] acc_q;

   if (STABLE_CYCLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) acc_q <= '0;
         else        acc_q <= raw_i;
      end
   end else begin : g_run
      localparam int RUN_W = $clog2(STABLE_CYCLES + 1);
      localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_CYCLES - 1);
      localparam logic [RUN_W-1:0] RUN_DONE = RUN_W'(STABLE_CYCLES);

      logic [CODE_W-1:0] cand_q;
      logic [RUN_W-1:0]  run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cand_q <= '0;
            run_q  <= RUN_DONE;
            acc_q  <= '0;
         end else if (raw_i != cand_q) begin
            cand_q <= raw_i;
            run_q  <= RUN_W'(1);
         end else if (run_q == RUN_LAST) begin
            acc_q <= cand_q;
            run_q <= RUN_DONE;
         end else if (run_q < RUN_LAST) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign code_o = acc_q;

endmodule

// File: rtl/pit_interval_counter.sv
module pit_interval_counter #(
   parameter int CNT_W = 16,
   parameter int OVF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             strobe_i,
   input  logic             active_i,
   input  logic [OVF_W-1:0] ovf_limit_i,
   output logic [CNT_W-1:0] count_o,
   output logic             timeout_o
);

   logic             strobe_prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic [OVF_W-1:0] ovf_q;
   logic             rise;
   logic             wrap;

   assign rise = strobe_i & ~strobe_prev_q;
   assign wrap = (cnt_q == {CNT_W{1'b1}}) && !rise && !restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_prev_q <= 1'b0;
         cnt_q         <= '0;
         ovf_q         <= '0;
      end else begin
         strobe_prev_q <= strobe_i;
         if (restart_i || rise) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
         if (restart_i)
            ovf_q <= '0;
         else if (active_i && wrap && ovf_q != {OVF_W{1'b1}})
            ovf_q <= ovf_q + 1'b1;
      end
   end

   assign count_o   = cnt_q;
   assign timeout_o = active_i && wrap && (ovf_limit_i != '0) &&
                      (({1'b0, ovf_q} + 1'b1) == {1'b0, ovf_limit_i});

endmodule

// File: rtl/phase_interval_timer.sv
module phase_interval_timer
   import pit_pkg::*;
#(
   parameter int              CNT_W         = 16,
   parameter int              CODE_W        = 8,
   parameter int              OVF_W         = 8,
   parameter int              SYNC_STAGES   = 2,
   parameter int              STABLE_CYCLES = 2,
   parameter logic [CODE_W-1:0] PHASE_CODE  = 8'h21,
   parameter logic [CODE_W-1:0] FAIL_CODE   = 8'hA4,
   parameter logic [CODE_W-1:0] PASS_CODE_A = 8'h22,
   parameter logic [CODE_W-1:0] PASS_CODE_B = 8'h2F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              strobe_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [OVF_W-1:0]  ovf_limit_i,
   output logic              tgt_rst_low_o,
   output logic              busy_o,
   output logic              res_valid_o,
   input  logic              res_ready_i,
   output logic [1:0]        res_kind_o,
   output logic [CNT_W-1:0]  res_count_o,
   output logic [CODE_W-1:0] res_code_o
);

   localparam int SYNC_W = CODE_W + 1;

   if (CNT_W < 2)         begin : g_bad_cnt    $error("CNT_W must be at least 2"); end
   if (SYNC_STAGES < 2)   begin : g_bad_sync   $error("SYNC_STAGES must be at least 2"); end
   if (STABLE_CYCLES < 1) begin : g_bad_stable $error("STABLE_CYCLES must be at least 1"); end
   if (PHASE_CODE == FAIL_CODE || PHASE_CODE == PASS_CODE_A || PHASE_CODE == PASS_CODE_B)
      begin : g_bad_codes $error("phase code must differ from the end codes"); end

   logic [SYNC_W-1:0] sync_q;
   logic              strobe_s;
   logic [CODE_W-1:0] code_s;
   logic [CODE_W-1:0] code_f;
   logic [CNT_W-1:0]  count;
   logic              timeout;
   logic              restart;
   logic              active;

   pit_state_e        st_q, st_d;
   pit_kind_e         kind_q, kind_d;
   logic [CNT_W-1:0]  cap_q, cap_d;
   logic [CODE_W-1:0] end_q, end_d;

   pit_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({strobe_i, code_i}),
      .q_o   (sync_q)
   );
   assign strobe_s = sync_q[SYNC_W-1];
   assign code_s   = sync_q[CODE_W-1:0];

   pit_code_filter #(.CODE_W(CODE_W), .STABLE_CYCLES(STABLE_CYCLES)) i_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (code_s),
      .code_o (code_f)
   );

   assign restart = (st_q == ST_IDLE) && start_i;
   assign active  = (st_q == ST_ENTER) || (st_q == ST_PHASE);

   pit_interval_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) i_counter (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart_i   (restart),
      .strobe_i    (strobe_s),
      .active_i    (active),
      .ovf_limit_i (ovf_limit_i),
      .count_o     (count),
      .timeout_o   (timeout)
   );

   always_comb begin
      st_d   = st_q;
      kind_d = kind_q;
      cap_d  = cap_q;
      end_d  = end_q;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) st_d = ST_ENTER;
         end
         ST_ENTER: begin
            if (timeout) begin
               st_d   = ST_REPORT;
               kind_d = KIND_TIMEOUT;
               cap_d  = '0;
               end_d  = code_f;
            end else if (code_f == PHASE_CODE) begin
               st_d = ST_PHASE;
            end
         end
         ST_PHASE: begin
            if (code_f != PHASE_CODE) begin
               st_d  = ST_REPORT;
               end_d = code_f;
               if (code_f == FAIL_CODE) begin
                  kind_d = KIND_FAIL;
                  cap_d  = count;
               end else if (code_f == PASS_CODE_A || code_f == PASS_CODE_B) begin
                  kind_d = KIND_PASS;
                  cap_d  = '0;
               end else begin
                  kind_d = KIND_ERROR;
                  cap_d  = '0;
               end
            end else if (timeout) begin
               st_d   = ST_REPORT;
               kind_d = KIND_TIMEOUT;
               cap_d  = '0;
               end_d  = code_f;
            end
         end
         ST_REPORT: begin
            if (res_ready_i) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= KIND_FAIL;
         cap_q  <= '0;
         end_q  <= '0;
      end else begin
         st_q   <= st_d;
         kind_q <= kind_d;
         cap_q  <= cap_d;
         end_q  <= end_d;
      end
   end

   assign tgt_rst_low_o = (st_q == ST_IDLE) || (st_q == ST_REPORT);
   assign busy_o        = (st_q != ST_IDLE);
   assign res_valid_o   = (st_q == ST_REPORT);
   assign res_kind_o    = kind_q;
   assign res_count_o   = cap_q;
   assign res_code_o    = end_q;

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int              CNT_W     = 16,
   parameter int              CODE_W    = 8,
   parameter logic [CODE_W-1:0] FAIL_CODE = 8'hA4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              tgt_rst_low_o,
   input logic              busy_o,
   input logic              res_valid_o,
   input logic              res_ready_i,
   input logic [1:0]        res_kind_o,
   input logic [CNT_W-1:0]  res_count_o,
   input logic [CODE_W-1:0] res_code_o
);

   a_r1_idle_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> tgt_rst_low_o);

   a_r1_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !tgt_rst_low_o);

   a_r1_result_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (tgt_rst_low_o && busy_o));

   a_r4_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_kind_o == 2'd0) |-> (res_code_o == FAIL_CODE));

   a_r5_r6_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_kind_o != 2'd0) |-> (res_count_o == '0));

   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i && start_i) |=> res_valid_o);

   a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_kind_o) && $stable(res_count_o) && $stable(res_code_o)));

   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_ready_i) |=> !busy_o);

endmodule

bind phase_interval_timer pit_checker #(
   .CNT_W     (CNT_W),
   .CODE_W    (CODE_W),
   .FAIL_CODE (FAIL_CODE)
) i_pit_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .tgt_rst_low_o (tgt_rst_low_o),
   .busy_o        (busy_o),
   .res_valid_o   (res_valid_o),
   .res_ready_i   (res_ready_i),
   .res_kind_o    (res_kind_o),
   .res_count_o   (res_count_o),
   .res_code_o    (res_code_o)
);

// File: tb/test_phase_interval_timer.sv
module test_phase_interval_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        strobe_i = 1'b0;
   logic [7:0]  code_i = 8'h00;
   logic [7:0]  ovf_limit_i = 8'd2;
   logic        res_ready_i = 1'b0;
   logic        tgt_rst_low_o, busy_o, res_valid_o;
   logic [1:0]  res_kind_o;
   logic [15:0] res_count_o;
   logic [7:0]  res_code_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   phase_interval_timer i_phase_interval_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(strobe_i),
      .code_i(code_i), .ovf_limit_i(ovf_limit_i), .tgt_rst_low_o(tgt_rst_low_o),
      .busy_o(busy_o), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
      .res_kind_o(res_kind_o), .res_count_o(res_count_o), .res_code_o(res_code_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_kind(input logic [7:0] c);
      if (c == 8'hA4) return 2'd0;
      if (c == 8'h22 || c == 8'h2F) return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic [15:0] exp_count(input logic [7:0] c, input int d);
      return (c == 8'hA4) ? 16'(d + 1) : 16'd0;
   endfunction

   task automatic wait_valid(input int limit);
      for (int i = 0; i < limit && !res_valid_o; i++) @(negedge clk);
   endtask

   task automatic consume(input string req, input logic [7:0] ec, input int d);
      wait_valid(30);
      chk({req, " R1 valid and reset driven"}, {30'd0, res_valid_o, tgt_rst_low_o}, 32'd3);
      chk({req, " R4/R5/R6 kind"}, 32'(res_kind_o), 32'(exp_kind(ec)));
      chk({req, " R2/R4 count"}, 32'(res_count_o), 32'(exp_count(ec, d)));
      chk({req, " R6 code"}, 32'(res_code_o), 32'(ec));
      start_i = 1'b1;                       // R9: ignored while result pending
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < int'($urandom_range(3, 0)); i++) @(negedge clk);
      chk({req, " R10 held"}, {13'd0, res_valid_o, res_kind_o, res_count_o},
          {13'd0, 1'b1, exp_kind(ec), exp_count(ec, d)});
      res_ready_i = 1'b1;
      @(negedge clk);
      res_ready_i = 1'b0;
      chk({req, " R10/R9 idle after ready"}, {29'd0, res_valid_o, busy_o, tgt_rst_low_o}, 32'd1);
      code_i = 8'h00;
      repeat (6) @(negedge clk);
   endtask

   task automatic run(input string req, input int d, input int nedges,
                      input logic [7:0] ec, input bit glitch, input bit poke);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk({req, " R1 released"}, {30'd0, tgt_rst_low_o, busy_o}, 32'd1);
      code_i = 8'h21;
      repeat (8) @(negedge clk);
      for (int e = 1; e < nedges; e++) begin
         strobe_i = 1'b1;
         @(negedge clk);
         strobe_i = 1'b0;
         repeat (int'($urandom_range(20, 5))) @(negedge clk);
      end
      strobe_i = 1'b1;
      for (int i = 1; i <= d; i++) begin
         @(negedge clk);
         if (i == 1) strobe_i = 1'b0;
         if (glitch && i == 2) code_i = 8'h55;       // R8 single-cycle value
         if (glitch && i == 3) code_i = 8'h21;
         start_i = poke && (i == 4);                 // R9 start during phase
         if (i == d) code_i = ec;
      end
      start_i = 1'b0;
      if (d < 1) code_i = ec;
      consume(req, ec, d);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 reset state", {29'd0, tgt_rst_low_o, busy_o, res_valid_o}, 32'd4);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 idle after reset", {29'd0, tgt_rst_low_o, busy_o, res_valid_o}, 32'd4);

      run("R4 fail two edges", 20, 2, 8'hA4, 1'b0, 1'b0);
      run("R5 pass 22", 15, 2, 8'h22, 1'b0, 1'b0);
      run("R5 pass 2F", 9, 1, 8'h2F, 1'b0, 1'b0);
      run("R6 error 55", 12, 3, 8'h55, 1'b0, 1'b0);
      run("R2 minimal interval", 1, 1, 8'hA4, 1'b0, 1'b0);
      run("R8 glitch ignored", 30, 2, 8'hA4, 1'b1, 1'b0);
      run("R9 start in phase", 40, 2, 8'hA4, 1'b0, 1'b1);
      run("R3 end right after entry", 6, 1, 8'hA4, 1'b1, 1'b1);

      for (int n = 0; n < 14; n++) begin
         logic [7:0] ec;
         int sel;
         sel = int'($urandom_range(3, 0));
         if (sel == 0) ec = 8'h22;
         else if (sel == 1) ec = 8'h2F;
         else if (sel == 2) begin
            ec = 8'($urandom);
            while (ec == 8'h21 || ec == 8'hA4 || ec == 8'h22 || ec == 8'h2F) ec = 8'($urandom);
         end else ec = 8'hA4;
         run("R2 random", int'($urandom_range(400, 6)), int'($urandom_range(3, 1)), ec,
             1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      end

      // R7: timeout after one wrap with no strobe and no end code
      ovf_limit_i = 8'd1;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      code_i = 8'h21;
      repeat (65520) @(negedge clk);
      chk("R7 no timeout yet", {31'd0, res_valid_o}, 32'd0);
      repeat (14) @(negedge clk);
      chk("R7 timeout boundary", {31'd0, res_valid_o}, 32'd0);
      repeat (2) @(negedge clk);
      chk("R7 timeout raised", {30'd0, res_valid_o, tgt_rst_low_o}, 32'd3);
      chk("R7 timeout kind", 32'(res_kind_o), 32'd3);
      chk("R7 timeout count/code", {8'd0, res_code_o, res_count_o}, {8'd0, 8'h21, 16'd0});
      res_ready_i = 1'b1;
      @(negedge clk);
      res_ready_i = 1'b0;
      chk("R10 idle after timeout", {30'd0, busy_o, tgt_rst_low_o}, 32'd1);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule